// File: doc/BRIEF.md
# Dual-Window Byte Memory with Gated Alias

This block is an on-chip byte store that sits on a simple request/response memory bus. It claims two adjacent address ranges of equal size, both starting on a boundary of twice the storage size. Both ranges map onto the same bytes. The lower range reads and writes without restriction. The upper range reads the same data, but accepts a write only while a 3-bit lock code holds the value that opens it. Firmware can keep a region read-only through one alias and still update it through the other, and it can open the second path with a single control load.

A request carries a byte address and a size of one, two or four bytes. A multi-byte access touches consecutive byte addresses in little-endian order at any alignment. All bytes of a request are handled in one cycle, because the storage is split into four byte banks. Each byte is decoded on its own. A byte that falls outside both ranges is dropped on a write and reads as zero. A byte in the upper range is written only if the lock code is open. Read data returns one cycle after the request, together with a valid flag. A separate strobe loads the lock code, and the code resets to the open value.

Top module: `nvaw_top`

## Requirements
- R1: A read of a byte in either range returns the stored byte at (address − BASE_ADDR) modulo CHIP_BYTES, so the two ranges return identical data.
- R2: A write to a byte in the lower range, [BASE_ADDR, BASE_ADDR+CHIP_BYTES), always stores that byte. A byte-size write stores only req_wdata[7:0].
- R3: A write to a byte in the upper range, [BASE_ADDR+CHIP_BYTES, BASE_ADDR+2*CHIP_BYTES), stores at offset modulo CHIP_BYTES only while the lock code equals 3'b111. Any other code, including 3'b110, discards the byte without a trace.
- R4: The lock code resets to 3'b111. When prot_load is high at a clock edge, prot_value is captured, and the new code governs requests from the following cycle on. A write in the same cycle as the load still sees the old code.
- R5: req_size 2'b00 selects one byte, 2'b01 two bytes, and 2'b10 or 2'b11 four bytes. Byte k of the access (k = 0..3) is at address req_addr+k and travels on data bits [8k+7:8k]. rsp_rdata bytes beyond the access size read zero.
- R6: For a multi-byte write, the range and lock decision is made per byte. In a write that straddles the two ranges while locked, the lower-range bytes are stored and the upper-range bytes are dropped.
- R7: Every read request yields exactly one cycle of rsp_valid in the next cycle, with its data. Writes and idle cycles yield no rsp_valid. After reset, rsp_valid and rsp_rdata are zero.
- R8: Bytes at addresses below BASE_ADDR or at or above BASE_ADDR+2*CHIP_BYTES are ignored on a write and read as zero. This includes the bytes of a wide access that spill past either end.
- R9: With INIT_MODE 0 the store starts all zero. With INIT_MODE 1 the byte at offset o starts as o[7:0] XOR 8'h5A.
- R10: An access of any size at any byte alignment completes in a single request cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (see R5) |
| req_addr | input | ADDR_W | Byte address of the lowest byte |
| req_wdata | input | 32 | Write data, little-endian byte lanes |
| prot_load | input | 1 | Load strobe for the lock code |
| prot_value | input | 3 | New lock code |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, little-endian byte lanes |

## Verification
The bench builds the block with CHIP_BYTES = 256, BASE_ADDR = 0x4000 and INIT_MODE = 1. The small size lets a pseudo-random address stream hit both range ends, the boundary between the ranges, and the spill-over bytes many times within a short run. The preload pattern lets the very first reads be checked against known data. With ADDR_W at 32, an access just below BASE_ADDR exercises the low-side drop, and the scoreboard model follows each byte and the lock code on its own.

// File: rtl/nvaw_pkg.sv
package nvaw_pkg;

   localparam int unsigned LANES = 4;
   localparam logic [2:0]  LOCK_OPEN = 3'b111;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_WORD2 = 2'b11
   } nvaw_size_e;

   function automatic logic [2:0] size_to_count(input logic [1:0] code);
      case (nvaw_size_e'(code))
         SZ_BYTE: return 3'd1;
         SZ_HALF: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/nvaw_lane_decode.sv
module nvaw_lane_decode #(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
   parameter int                CHIP_BYTES = 2048,
   parameter int                LANE       = 0
) (
   input  logic [ADDR_W-1:0]             addr,
   input  logic [2:0]                    count,
   output logic                          hit,
   output logic                          win1,
   output logic [$clog2(CHIP_BYTES)-1:0] off
);
   localparam int             OFF_W = $clog2(CHIP_BYTES);
   localparam int             AW1   = ADDR_W + 1;
   localparam logic [AW1-1:0] LO    = {1'b0, BASE_ADDR};
   localparam logic [AW1-1:0] MID   = LO + AW1'(CHIP_BYTES);
   localparam logic [AW1-1:0] HI    = LO + AW1'(2 * CHIP_BYTES);

   logic [AW1-1:0] byte_addr;

   // widened sum so a carry past the top of the address space stays out of range
   assign byte_addr = {1'b0, addr} + AW1'(LANE);
   assign hit       = (3'(LANE) < count) && (byte_addr >= LO) && (byte_addr < HI);
   assign win1      = (byte_addr >= MID);
   assign off       = byte_addr[OFF_W-1:0];

endmodule

// File: rtl/nvaw_byte_bank.sv
module nvaw_byte_bank #(
   parameter int DEPTH     = 512,
   parameter int INIT_MODE = 0,
   parameter int BANK_IDX  = 0,
   parameter int STRIDE    = 4
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic                     re,
   input  logic [$clog2(DEPTH)-1:0] row,
   input  logic [7:0]               wdata,
   output logic [7:0]               rdata
);
   logic [7:0] mem [DEPTH];

   generate
      if (INIT_MODE == 1) begin : g_preload
         initial begin
            for (int r = 0; r < DEPTH; r++)
               mem[r] = 8'(r * STRIDE + BANK_IDX) ^ 8'h5A;
         end
      end else begin : g_zero
         initial begin
            for (int r = 0; r < DEPTH; r++)
               mem[r] = 8'h00;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we)
         mem[row] <= wdata;
      if (re)
         rdata <= mem[row];
   end

endmodule

// File: rtl/nvaw_prot_reg.sv
module nvaw_prot_reg
   import nvaw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [2:0] value,
   output logic [2:0] code,
   output logic       open
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code <= LOCK_OPEN;
      else if (load)
         code <= value;
   end

   assign open = (code == LOCK_OPEN);

   AST_PROT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (code == $past(value)));                     // R4
   AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(code));                               // R4

endmodule

// File: rtl/nvaw_top.sv
module nvaw_top
   import nvaw_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h0000_4000,
   parameter int                CHIP_BYTES = 2048,
   parameter int                INIT_MODE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic              prot_load,
   input  logic [2:0]        prot_value,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata
);
   localparam int OFF_W = $clog2(CHIP_BYTES);
   localparam int DEPTH = CHIP_BYTES / LANES;
   localparam int ROW_W = $clog2(DEPTH);

   // elaboration-time parameter checks
   generate
      if (CHIP_BYTES < 2 * LANES || (CHIP_BYTES & (CHIP_BYTES - 1)) != 0) begin : g_bad_size
         $error("nvaw_top: CHIP_BYTES must be a power of two of at least 8");
      end
      if (BASE_ADDR[OFF_W:0] != '0) begin : g_bad_base
         $error("nvaw_top: BASE_ADDR must be aligned to 2*CHIP_BYTES");
      end
      if (INIT_MODE != 0 && INIT_MODE != 1) begin : g_bad_init
         $error("nvaw_top: INIT_MODE must be 0 or 1");
      end
      if (ADDR_W <= OFF_W + 1) begin : g_bad_aw
         $error("nvaw_top: ADDR_W too small for two windows");
      end
   endgenerate

   logic [2:0]       count;
   logic [2:0]       lock_code;
   logic             lock_open;
   logic             rd_req;
   logic             wr_req;

   logic             lane_hit  [LANES];
   logic             lane_win1 [LANES];
   logic [OFF_W-1:0] lane_off  [LANES];
   logic [LANES-1:0] lane_ren;

   logic [LANES-1:0] bank_we;
   logic [LANES-1:0] bank_re;
   logic [LANES-1:0] bank_win1;
   logic [ROW_W-1:0] bank_row  [LANES];
   logic [7:0]       bank_wd   [LANES];
   logic [7:0]       bank_rd   [LANES];

   logic [1:0]       rot_q;
   logic [LANES-1:0] mask_q;

   assign count  = size_to_count(req_size);
   assign rd_req = req_valid && !req_write;
   assign wr_req = req_valid &&  req_write;

   nvaw_prot_reg u_prot (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (prot_load),
      .value (prot_value),
      .code  (lock_code),
      .open  (lock_open)
   );

   // per-byte address decode, lane k handles address req_addr+k
   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         nvaw_lane_decode #(
            .ADDR_W     (ADDR_W),
            .BASE_ADDR  (BASE_ADDR),
            .CHIP_BYTES (CHIP_BYTES),
            .LANE       (k)
         ) u_dec (
            .addr  (req_addr),
            .count (count),
            .hit   (lane_hit[k]),
            .win1  (lane_win1[k]),
            .off   (lane_off[k])
         );
         assign lane_ren[k] = rd_req && lane_hit[k];
      end
   endgenerate

   // crossbar: bank b serves the lane whose address ends in b
   generate
      for (genvar b = 0; b < LANES; b++) begin : g_bank
         logic [1:0] sel;
         assign sel          = 2'(b) - req_addr[1:0];
         assign bank_row[b]  = lane_off[sel][OFF_W-1:2];
         assign bank_win1[b] = lane_win1[sel];
         assign bank_wd[b]   = req_wdata[{sel, 3'b000} +: 8];
         assign bank_re[b]   = lane_ren[sel];
         assign bank_we[b]   = wr_req && lane_hit[sel] && (!lane_win1[sel] || lock_open);

         nvaw_byte_bank #(
            .DEPTH     (DEPTH),
            .INIT_MODE (INIT_MODE),
            .BANK_IDX  (b),
            .STRIDE    (LANES)
         ) u_bank (
            .clk   (clk),
            .we    (bank_we[b]),
            .re    (bank_re[b]),
            .row   (bank_row[b]),
            .wdata (bank_wd[b]),
            .rdata (bank_rd[b])
         );
      end
   endgenerate

   // response bookkeeping for the registered read path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rot_q     <= '0;
         mask_q    <= '0;
      end else begin
         rsp_valid <= rd_req;
         rot_q     <= req_addr[1:0];
         mask_q    <= lane_ren;
      end
   end

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_ret
         logic [1:0] src;
         assign src = rot_q + 2'(k);
         assign rsp_rdata[8*k +: 8] = mask_q[k] ? bank_rd[src] : 8'h00;
      end
   endgenerate

   AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid);                                   // R7
   AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rsp_valid);                                 // R7
   AST_LOCKED_WIN1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && lock_code != LOCK_OPEN) |-> ((bank_we & bank_win1) == '0)); // R3
   AST_WE_WITHIN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> ($countones(bank_we) <= 32'(count)));          // R5
   AST_NO_WE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |-> (bank_we == '0));                             // R2
   AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && lane_ren == '0) |=> (rsp_rdata == 32'h0));     // R8

endmodule

// File: tb/nvaw_top_test.sv
`timescale 1ns/1ps
module nvaw_top_test;
   localparam int          CHIP = 256;
   localparam logic [31:0] BASE = 32'h0000_4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        prot_load = 1'b0;
   logic [2:0]  prot_value = 3'b000;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;

   always #2 clk = ~clk;

   nvaw_top #(
      .ADDR_W     (32),
      .BASE_ADDR  (BASE),
      .CHIP_BYTES (CHIP),
      .INIT_MODE  (1)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_size   (req_size),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .prot_load  (prot_load),
      .prot_value (prot_value),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata)
   );

   typedef struct {
      logic [31:0] data;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [7:0]  ref_mem [CHIP];
   logic [2:0]  ref_lock = 3'b111;
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          mon_on = 1'b0;
   bit          finished = 1'b0;
   logic [31:0] lfsr = 32'h1D87_2C45;

   function automatic int nbytes(input logic [1:0] sz);
      return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
   endfunction

   function automatic logic [31:0] model_read(input logic [31:0] ad, input logic [1:0] sz);
      logic [31:0] v = '0;
      for (int k = 0; k < nbytes(sz); k++) begin
         longint a = longint'(ad) + k;
         if (a >= longint'(BASE) && a < longint'(BASE) + 2 * CHIP)
            v[8*k +: 8] = ref_mem[int'((a - longint'(BASE)) % CHIP)];
      end
      return v;
   endfunction

   task automatic model_write(input logic [31:0] ad, input logic [1:0] sz, input logic [31:0] wd);
      for (int k = 0; k < nbytes(sz); k++) begin
         longint a = longint'(ad) + k;
         if (a >= longint'(BASE) && a < longint'(BASE) + 2 * CHIP) begin
            if (a < longint'(BASE) + CHIP || ref_lock == 3'b111)
               ref_mem[int'((a - longint'(BASE)) % CHIP)] = wd[8*k +: 8];
         end
      end
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // driver: one bus cycle per call
   task automatic drive(input bit v, input bit w, input logic [1:0] sz, input logic [31:0] ad,
                        input logic [31:0] wd, input bit pl, input logic [2:0] pv, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid  = v;
      req_write  = w;
      req_size   = sz;
      req_addr   = ad;
      req_wdata  = wd;
      prot_load  = pl;
      prot_value = pv;
      if (v && !w) begin
         e.data = model_read(ad, sz);
         e.tag  = tag;
         sb.push_back(e);
      end
      if (v && w)
         model_write(ad, sz, wd);
      if (pl)
         ref_lock = pv;
   endtask

   task automatic rd(input logic [1:0] sz, input logic [31:0] ad, input string tag);
      drive(1, 0, sz, ad, 32'h0, 0, 3'b000, tag);
   endtask

   task automatic wr(input logic [1:0] sz, input logic [31:0] ad, input logic [31:0] wd);
      drive(1, 1, sz, ad, wd, 0, 3'b000, "");
   endtask

   task automatic lock(input logic [2:0] pv);
      drive(0, 0, 2'b00, 32'h0, 32'h0, 1, pv, "");
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++)
         drive(0, 0, 2'b00, 32'h0, 32'h0, 0, 3'b000, "");
   endtask

   // monitor: pops one expected item per response
   always @(negedge clk) begin
      if (mon_on && rsp_valid) begin
         if (sb.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R7: actual rsp_valid=1 expected 0 (no read pending)");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, rsp_rdata, e.data);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int o = 0; o < CHIP; o++)
         ref_mem[o] = 8'(o) ^ 8'h5A;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R7 reset valid", {31'h0, rsp_valid}, 32'h0);
      check("R7 reset data", rsp_rdata, 32'h0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      idle(1);

      // preload, aliasing and unaligned reads
      rd(2'b00, BASE + 32'h0, "R9 preload byte 0");
      rd(2'b00, BASE + CHIP + 32'h0, "R1 alias byte 0");
      rd(2'b10, BASE + 32'h5, "R10 unaligned word");
      rd(2'b01, BASE + CHIP + 32'h11, "R5 odd halfword alias");
      rd(2'b11, BASE + CHIP - 32'h4, "R5 size code 11 word");

      // lower range write, only low byte
      wr(2'b00, BASE + 32'h3, 32'h1234_56C3);
      rd(2'b00, BASE + 32'h3, "R2 byte write lower");
      rd(2'b10, BASE + CHIP + 32'h0, "R2 alias sees lower write");

      // upper range write with reset lock code
      wr(2'b10, BASE + CHIP + 32'h20, 32'hA1B2_C3D4);
      rd(2'b10, BASE + 32'h20, "R4 default open upper write");
      wr(2'b01, BASE + CHIP + 32'h41, 32'h0000_7E6D);
      rd(2'b10, BASE + 32'h40, "R3 upper halfword while open");

      // lock and retry
      lock(3'b011);
      wr(2'b00, BASE + CHIP + 32'h30, 32'h0000_00EE);
      rd(2'b00, BASE + 32'h30, "R3 locked upper byte dropped");
      wr(2'b00, BASE + 32'h31, 32'h0000_0077);
      rd(2'b01, BASE + CHIP + 32'h30, "R2 lower write while locked");

      // straddling write, per-byte decision
      wr(2'b10, BASE + CHIP - 32'h2, 32'h4433_2211);
      rd(2'b10, BASE + CHIP - 32'h2, "R6 straddle locked");
      lock(3'b110);
      wr(2'b10, BASE + CHIP + 32'h50, 32'hDEAD_BEEF);
      rd(2'b10, BASE + 32'h50, "R3 code 110 still locked");
      lock(3'b111);
      wr(2'b10, BASE + CHIP - 32'h2, 32'h8877_6655);
      rd(2'b10, BASE + CHIP - 32'h2, "R6 straddle open");

      // load in same cycle as a write: old code applies
      drive(1, 1, 2'b00, BASE + CHIP + 32'h60, 32'h0000_0099, 1, 3'b000, "");
      rd(2'b00, BASE + 32'h60, "R4 same-cycle load uses old code");
      wr(2'b00, BASE + CHIP + 32'h61, 32'h0000_0033);
      rd(2'b01, BASE + 32'h60, "R4 new code blocks next write");
      lock(3'b111);

      // outside both ranges
      wr(2'b00, BASE + 2 * CHIP, 32'h0000_00F0);
      rd(2'b00, BASE + 32'h0, "R8 write above range ignored");
      rd(2'b00, BASE + 2 * CHIP, "R8 read above range zero");
      rd(2'b10, BASE + 2 * CHIP - 32'h2, "R8 top spill zero");
      rd(2'b10, BASE - 32'h1, "R8 bottom spill zero");
      wr(2'b01, BASE - 32'h1, 32'h0000_C4B3);
      rd(2'b10, BASE - 32'h4, "R8 below-range write ignored");
      rd(2'b01, BASE + 32'h0, "R8 in-range half of spill written");
      rd(2'b10, 32'hFFFF_FFFE, "R8 address wrap stays outside");

      // back-to-back reads and writes, then idle: no stray responses
      rd(2'b00, BASE + 32'h7, "R7 back-to-back a");
      rd(2'b00, BASE + 32'h8, "R7 back-to-back b");
      wr(2'b00, BASE + 32'h9, 32'h0000_0011);
      rd(2'b00, BASE + 32'h9, "R7 read after write");
      idle(3);

      // pseudo-random mixed traffic
      for (int i = 0; i < 600; i++) begin
         logic [31:0] ad;
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         ad = BASE - 32'd8 + (lfsr % (2 * CHIP + 16));
         if (lfsr[27:24] == 4'h0)
            lock(lfsr[22:20]);
         else if (lfsr[28])
            drive(1, 1, lfsr[30:29], ad, {lfsr[15:0], lfsr[31:16]}, 0, 3'b000, "");
         else
            rd(lfsr[30:29], ad, "R1 mixed traffic");
      end

      idle(4);
      check("R7 all reads answered", 32'(sb.size()), 32'h0);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule